// File: doc/BRIEF.md
# 16-bit I/O Slave Port for a PC Expansion Bus

This block sits on an expansion card and connects the host's 16-bit I/O bus to a small internal register file. It compares the ten I/O address bits with a fixed base window. A cycle is accepted only when the address-enable line shows that the processor owns the bus and a DMA controller does not. As soon as the address falls inside the window, the block pulls the 16-bit I/O acknowledge low, before any strobe arrives. This serves hosts that sample the acknowledge early.

The block works out which data lanes carry the transfer from the byte-high-enable line and address bit 0. It then turns bus reads and writes into a simple register port: a word index, byte enables, write data, a one-cycle write pulse and a one-cycle read pulse. Read data goes back onto the bus on the proper lanes, with a separate drive enable for each lane. While the register file reports that it is busy, the block stretches the cycle by driving channel-ready low, for a bounded time only. On byte cycles with ready data it may request a cycle without wait states instead.

Bus strobes, AEN and SBHE are taken as inputs that are already synchronous to `clk_i`. Every active-low bus output is given as a drive-enable or a level, and the pad ring resolves it.

Top module: `isa_io_slave`

## Requirements
- R1: The window is hit when aen_i is 0 and address bits 9 down to WIN_W equal the same bits of BASE (defaults: BASE=0x300, WIN_W=4, so the window is 0x300..0x30F). reg_idx_o is address bits WIN_W-1 down to 1.
- R2: While aen_i is 1, the block does not react to I/O strobes. io16_no stays 1, both lane enables stay 0, and reg_wr_o, reg_rd_o, chrdy_oe_o and nows_oe_o stay 0.
- R3: io16_no goes low in the same cycle that a hit address is present, whether or not any strobe is active. It is high whenever there is no hit.
- R4: Lane mapping from (sbhe_ni, address bit 0) to the transfer and its byte enables (bit 1 = upper byte):
  - (0,0): a full word, byte enables 11.
  - (0,1): the odd byte on data bits 15:8, byte enables 10.
  - (1,0): the even byte on bits 7:0, byte enables 01.
  - (1,1): the odd byte carried on bits 7:0, byte enables 10.
- R5: A write is captured when iow_ni rises after a hit cycle. reg_wr_o then pulses for exactly one clock, in the cycle after the first clock edge that samples iow_ni high. The pulse carries the index, byte enables and data from the last low-strobe cycle.
- R6: A word written as two byte cycles (even address with sbhe_ni=1, then odd address with sbhe_ni=1) leaves each byte in its correct half of the register.
- R7: sd_lo_oe_o and sd_hi_oe_o are 1 only while ior_ni is 0 and the window is hit, and only for the lanes used in R4. In case (1,1), sd_o[7:0] carries the register's upper byte.
- R8: reg_rd_o pulses for one clock in the first cycle of a hit read. reg_rdata_i is passed to the enabled lanes in that same cycle.
- R9: While a hit strobe is active and reg_ready_i is 0, chrdy_oe_o is 1. It drops in the same cycle that reg_ready_i rises, and it is never 1 for more than MAX_WAIT consecutive cycles (default 8).
- R10: nows_oe_o is 1 only during a hit strobe of a byte cycle (sbhe_ni=1) with reg_ready_i at 1. It is never 1 together with chrdy_oe_o.
- R11: After reset, io16_no is 1 and every enable and pulse output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sa_i | input | ADDR_W | I/O address bits 9:0 |
| aen_i | input | 1 | High during DMA-owned cycles |
| ior_ni | input | 1 | I/O read strobe, active low |
| iow_ni | input | 1 | I/O write strobe, active low |
| sbhe_ni | input | 1 | Byte-high enable, active low |
| sd_i | input | 16 | Data bus, inbound |
| sd_o | output | 16 | Data bus, outbound |
| sd_lo_oe_o | output | 1 | Drive enable for bits 7:0 |
| sd_hi_oe_o | output | 1 | Drive enable for bits 15:8 |
| io16_no | output | 1 | 16-bit I/O acknowledge, active low |
| chrdy_oe_o | output | 1 | Pull channel-ready low |
| nows_oe_o | output | 1 | Pull no-wait-state low |
| reg_idx_o | output | IDX_W | Register word index |
| reg_be_o | output | 2 | Byte enables |
| reg_wdata_o | output | 16 | Write data |
| reg_wr_o | output | 1 | One-cycle write pulse |
| reg_rd_o | output | 1 | One-cycle read pulse |
| reg_rdata_i | input | 16 | Register read data |
| reg_ready_i | input | 1 | Register file ready |

## Verification
The block holds three pieces of internal state: the write-capture latch with its armed flag, the read-seen flag and the wait counter.

- **Write-capture latch.** A wrong armed flag or wrong captured fields show up one clock after the write strobe rises. The pulse may be missing, doubled, or carry the wrong bytes. A bench register model that merges by byte enable shows this as a corrupted word.
- **Read-seen flag.** A stale flag removes or repeats reg_rd_o in the first cycle of a read.
- **Wait counter.** A miscounted counter changes how many cycles chrdy_oe_o stays high. Counting samples of chrdy_oe_o against MAX_WAIT exposes it by the end of the stretched cycle.

// File: rtl/isa_io_pkg.sv
package isa_io_pkg;
  localparam int DATA_W    = 16;
  localparam int NUM_LANES = DATA_W / 8;

  typedef enum logic [1:0] {
    LANE_WORD = 2'd0,
    LANE_LO   = 2'd1,
    LANE_HI   = 2'd2,
    LANE_XLO  = 2'd3   // odd byte carried on low lane
  } lane_e;
endpackage

// File: rtl/isa_io_decode.sv
module isa_io_decode
  import isa_io_pkg::*;
#(
  parameter int          ADDR_W = 10,
  parameter int          WIN_W  = 4,
  parameter logic [9:0]  BASE   = 10'h300
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              aen_i,
  input  logic              sbhe_ni,
  output logic              hit_o,
  output lane_e             lane_o,
  output logic [WIN_W-2:0]  idx_o
);
  localparam int TAG_W = ADDR_W - WIN_W;

  logic [TAG_W-1:0] base_tag;
  assign base_tag = BASE[ADDR_W-1:WIN_W];

  assign hit_o = !aen_i && (addr_i[ADDR_W-1:WIN_W] == base_tag);
  assign idx_o = addr_i[WIN_W-1:1];

  always_comb begin
    unique case ({sbhe_ni, addr_i[0]})
      2'b00:   lane_o = LANE_WORD;
      2'b01:   lane_o = LANE_HI;
      2'b10:   lane_o = LANE_LO;
      default: lane_o = LANE_XLO;
    endcase
  end
endmodule

// File: rtl/isa_io_lanes.sv
module isa_io_lanes
  import isa_io_pkg::*;
(
  input  lane_e               lane_i,
  input  logic [DATA_W-1:0]   bus_i,
  input  logic [DATA_W-1:0]   rdata_i,
  output logic [DATA_W-1:0]   wdata_o,
  output logic [DATA_W-1:0]   bus_o,
  output logic [NUM_LANES-1:0] be_o,
  output logic [NUM_LANES-1:0] use_o
);
  logic swap;
  assign swap = (lane_i == LANE_XLO);

  always_comb begin
    unique case (lane_i)
      LANE_WORD: begin be_o = 2'b11; use_o = 2'b11; end
      LANE_LO:   begin be_o = 2'b01; use_o = 2'b01; end
      LANE_HI:   begin be_o = 2'b10; use_o = 2'b10; end
      default:   begin be_o = 2'b10; use_o = 2'b01; end
    endcase
  end

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    if (k == 0) begin : g_low
      assign bus_o[7:0]   = swap ? rdata_i[15:8] : rdata_i[7:0];
      assign wdata_o[7:0] = bus_i[7:0];
    end else begin : g_up
      assign bus_o[8*k +: 8]   = rdata_i[8*k +: 8];
      assign wdata_o[8*k +: 8] = swap ? bus_i[7:0] : bus_i[8*k +: 8];
    end
  end
endmodule

// File: rtl/isa_io_wrcap.sv
module isa_io_wrcap
  import isa_io_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 hit_i,
  input  logic                 iow_ni,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [NUM_LANES-1:0] be_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic                 wr_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic [NUM_LANES-1:0] be_o,
  output logic [DATA_W-1:0]    wdata_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      wr_o    <= 1'b0;
      idx_o   <= '0;
      be_o    <= '0;
      wdata_o <= '0;
    end else begin
      wr_o <= 1'b0;
      if (!iow_ni && hit_i) begin
        armed_q <= 1'b1;
        idx_o   <= idx_i;
        be_o    <= be_i;
        wdata_o <= wdata_i;
      end else if (armed_q && iow_ni) begin
        armed_q <= 1'b0;
        wr_o    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/isa_io_ready.sv
module isa_io_ready #(
  parameter int MAX_WAIT = 8,
  parameter bit EN_NOWS  = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_i,
  input  logic byte_cyc_i,
  input  logic ready_i,
  output logic chrdy_oe_o,
  output logic nows_oe_o
);
  localparam int CNT_W = $clog2(MAX_WAIT + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_WAIT);

  logic [CNT_W-1:0] cnt_q;

  assign chrdy_oe_o = cmd_i && !ready_i && (cnt_q < LIMIT);

  if (EN_NOWS) begin : g_nows
    assign nows_oe_o = cmd_i && ready_i && byte_cyc_i;
  end else begin : g_no_nows
    assign nows_oe_o = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!cmd_i)     cnt_q <= '0;
    else if (chrdy_oe_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/isa_io_slave.sv
module isa_io_slave
  import isa_io_pkg::*;
#(
  parameter int         ADDR_W   = 10,
  parameter int         WIN_W    = 4,
  parameter logic [9:0] BASE     = 10'h300,
  parameter int         MAX_WAIT = 8,
  parameter bit         EN_NOWS  = 1'b1,
  localparam int        IDX_W    = WIN_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] sa_i,
  input  logic              aen_i,
  input  logic              ior_ni,
  input  logic              iow_ni,
  input  logic              sbhe_ni,
  input  logic [15:0]       sd_i,
  output logic [15:0]       sd_o,
  output logic              sd_lo_oe_o,
  output logic              sd_hi_oe_o,
  output logic              io16_no,
  output logic              chrdy_oe_o,
  output logic              nows_oe_o,
  output logic [IDX_W-1:0]  reg_idx_o,
  output logic [1:0]        reg_be_o,
  output logic [15:0]       reg_wdata_o,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  input  logic [15:0]       reg_rdata_i,
  input  logic              reg_ready_i
);
  logic                 hit;
  lane_e                lane;
  logic [IDX_W-1:0]     dec_idx;
  logic [DATA_W-1:0]    bus_wdata;
  logic [NUM_LANES-1:0] cur_be, lane_use;
  logic                 cap_wr;
  logic [IDX_W-1:0]     cap_idx;
  logic [NUM_LANES-1:0] cap_be;
  logic                 rd_act, cmd, rd_seen_q;

  isa_io_decode #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .BASE(BASE)) u_dec (
    .addr_i (sa_i),
    .aen_i  (aen_i),
    .sbhe_ni(sbhe_ni),
    .hit_o  (hit),
    .lane_o (lane),
    .idx_o  (dec_idx)
  );

  isa_io_lanes u_lanes (
    .lane_i (lane),
    .bus_i  (sd_i),
    .rdata_i(reg_rdata_i),
    .wdata_o(bus_wdata),
    .bus_o  (sd_o),
    .be_o   (cur_be),
    .use_o  (lane_use)
  );

  isa_io_wrcap #(.IDX_W(IDX_W)) u_wr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .iow_ni (iow_ni),
    .idx_i  (dec_idx),
    .be_i   (cur_be),
    .wdata_i(bus_wdata),
    .wr_o   (cap_wr),
    .idx_o  (cap_idx),
    .be_o   (cap_be),
    .wdata_o(reg_wdata_o)
  );

  assign rd_act = hit && !ior_ni;
  assign cmd    = hit && (!ior_ni || !iow_ni);

  isa_io_ready #(.MAX_WAIT(MAX_WAIT), .EN_NOWS(EN_NOWS)) u_rdy (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd),
    .byte_cyc_i(sbhe_ni),
    .ready_i   (reg_ready_i),
    .chrdy_oe_o(chrdy_oe_o),
    .nows_oe_o (nows_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_seen_q <= 1'b0;
    else         rd_seen_q <= rd_act;
  end

  assign io16_no    = !hit;
  assign sd_lo_oe_o = rd_act && lane_use[0];
  assign sd_hi_oe_o = rd_act && lane_use[1];
  assign reg_rd_o   = rd_act && !rd_seen_q;
  assign reg_wr_o   = cap_wr;
  assign reg_idx_o  = cap_wr ? cap_idx : dec_idx;
  assign reg_be_o   = cap_wr ? cap_be : cur_be;
endmodule

// File: rtl/isa_io_slave_chk.sv
module isa_io_slave_chk #(
  parameter int MAX_WAIT = 8
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       aen_i,
  input logic       ior_ni,
  input logic       iow_ni,
  input logic       sd_lo_oe_o,
  input logic       sd_hi_oe_o,
  input logic       io16_no,
  input logic       chrdy_oe_o,
  input logic       nows_oe_o,
  input logic [1:0] reg_be_o,
  input logic       reg_wr_o,
  input logic       reg_rd_o
);
  localparam int CW = $clog2(MAX_WAIT + 2);
  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         run_q <= '0;
    else if (chrdy_oe_o) run_q <= run_q + 1'b1;
    else                 run_q <= '0;
  end

  assert_aen_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aen_i |-> (io16_no && !sd_lo_oe_o && !sd_hi_oe_o && !chrdy_oe_o && !nows_oe_o && !reg_rd_o));

  assert_io16_with_drive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_lo_oe_o || sd_hi_oe_o || chrdy_oe_o) |-> !io16_no);

  assert_be_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> (reg_be_o != 2'b00));

  assert_wr_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o);

  assert_wr_after_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> ($past(iow_ni) && !$past(iow_ni, 2)));

  assert_drive_on_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_lo_oe_o || sd_hi_oe_o) |-> !ior_ni);

  assert_rd_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |=> !reg_rd_o);

  assert_chrdy_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= CW'(MAX_WAIT));

  assert_ready_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(chrdy_oe_o && nows_oe_o));
endmodule

bind isa_io_slave isa_io_slave_chk #(.MAX_WAIT(MAX_WAIT)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .aen_i     (aen_i),
  .ior_ni    (ior_ni),
  .iow_ni    (iow_ni),
  .sd_lo_oe_o(sd_lo_oe_o),
  .sd_hi_oe_o(sd_hi_oe_o),
  .io16_no   (io16_no),
  .chrdy_oe_o(chrdy_oe_o),
  .nows_oe_o (nows_oe_o),
  .reg_be_o  (reg_be_o),
  .reg_wr_o  (reg_wr_o),
  .reg_rd_o  (reg_rd_o)
);

// File: tb/isa_io_slave_test.sv
module isa_io_slave_test;
  localparam int         MAXW = 6;
  localparam logic [9:0] BASE = 10'h300;

  logic        clk_i = 0, rst_ni = 0;
  logic [9:0]  sa_i = 0;
  logic        aen_i = 0, ior_ni = 1, iow_ni = 1, sbhe_ni = 1;
  logic [15:0] sd_i = 0, sd_o, reg_wdata_o, reg_rdata_i;
  logic        sd_lo_oe_o, sd_hi_oe_o, io16_no, chrdy_oe_o, nows_oe_o;
  logic [2:0]  reg_idx_o;
  logic [1:0]  reg_be_o;
  logic        reg_wr_o, reg_rd_o, reg_ready_i = 1;

  logic [15:0] mem [8];
  logic [15:0] exp_mem [8];
  int checks = 0, errors = 0, cyc = 0;

  always #4 clk_i = ~clk_i;

  isa_io_slave #(.BASE(BASE), .MAX_WAIT(MAXW)) uut (.*);

  assign reg_rdata_i = mem[reg_idx_o];

  always_ff @(posedge clk_i) begin
    if (reg_wr_o) begin
      if (reg_be_o[0]) mem[reg_idx_o][7:0]  <= reg_wdata_o[7:0];
      if (reg_be_o[1]) mem[reg_idx_o][15:8] <= reg_wdata_o[15:8];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic bit f_hit(input logic [9:0] a, input logic aen);
    return !aen && (a[9:4] == BASE[9:4]);
  endfunction

  function automatic logic [1:0] f_use(input logic sb, input logic a0);
    case ({sb, a0})
      2'b00: return 2'b11;
      2'b01: return 2'b10;
      default: return 2'b01;
    endcase
  endfunction

  function automatic logic [15:0] f_merge(input logic [15:0] old, input logic sb,
                                          input logic a0, input logic [15:0] d);
    case ({sb, a0})
      2'b00: return d;
      2'b01: return {d[15:8], old[7:0]};
      2'b10: return {old[15:8], d[7:0]};
      default: return {d[7:0], old[7:0]};
    endcase
  endfunction

  function automatic logic [15:0] f_rd(input logic [15:0] w, input logic sb, input logic a0);
    return (sb && a0) ? {w[15:8], w[15:8]} : w;
  endfunction

  task automatic do_write(input logic [9:0] a, input logic sb, input logic [15:0] d, input logic aen);
    bit h = f_hit(a, aen);
    @(negedge clk_i);
    sa_i = a; sbhe_ni = sb; aen_i = aen;
    #1 chk(io16_no == !h, "R3 io16 before strobe", io16_no, !h);
    @(negedge clk_i);
    iow_ni = 0; sd_i = d;
    #1 chk(nows_oe_o == (h && sb), "R10 nows on write", nows_oe_o, h && sb);
    @(negedge clk_i);
    iow_ni = 1;
    @(negedge clk_i);
    chk(reg_wr_o == h, h ? "R5 write pulse" : "R2 no write", reg_wr_o, h);
    @(negedge clk_i);
    chk(reg_wr_o == 0, "R5 single pulse", reg_wr_o, 0);
    if (h) exp_mem[a[3:1]] = f_merge(exp_mem[a[3:1]], sb, a[0], d);
    chk(mem[a[3:1]] == exp_mem[a[3:1]], "R4 R1 register content", mem[a[3:1]], exp_mem[a[3:1]]);
    aen_i = 0;
  endtask

  task automatic do_read(input logic [9:0] a, input logic sb, input logic aen);
    bit h = f_hit(a, aen);
    logic [1:0] u = h ? f_use(sb, a[0]) : 2'b00;
    logic [15:0] e = f_rd(exp_mem[a[3:1]], sb, a[0]);
    @(negedge clk_i);
    sa_i = a; sbhe_ni = sb; aen_i = aen; ior_ni = 0;
    #1;
    chk({sd_hi_oe_o, sd_lo_oe_o} == u, h ? "R7 lane enables" : "R2 no drive", {sd_hi_oe_o, sd_lo_oe_o}, u);
    chk(reg_rd_o == h, "R8 read pulse", reg_rd_o, h);
    if (u[0]) chk(sd_o[7:0] == e[7:0], "R7 low lane data", sd_o[7:0], e[7:0]);
    if (u[1]) chk(sd_o[15:8] == e[15:8], "R7 high lane data", sd_o[15:8], e[15:8]);
    @(negedge clk_i);
    chk(reg_rd_o == 0, "R8 read pulse ends", reg_rd_o, 0);
    ior_ni = 1;
    #1 chk({sd_hi_oe_o, sd_lo_oe_o} == 2'b00, "R7 release", {sd_hi_oe_o, sd_lo_oe_o}, 0);
    aen_i = 0;
  endtask

  initial begin
    int n;
    void'($urandom(32'h1a5a));
    for (int i = 0; i < 8; i++) begin mem[i] = 16'h0; exp_mem[i] = 16'h0; end
    #1;
    chk(io16_no == 1 && !sd_lo_oe_o && !sd_hi_oe_o && !reg_wr_o && !chrdy_oe_o,
        "R11 reset state", {io16_no, sd_lo_oe_o, sd_hi_oe_o, reg_wr_o, chrdy_oe_o}, 5'b10000);
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // directed lane cases
    do_write(10'h304, 0, 16'hBEEF, 0);
    do_read (10'h304, 0, 0);
    do_write(10'h306, 1, 16'h0012, 0);          // R6 split: even byte
    do_write(10'h307, 1, 16'h0034, 0);          // R6 split: odd byte on low lane
    chk(mem[3] == 16'h3412, "R6 split word", mem[3], 16'h3412);
    do_read (10'h307, 1, 0);
    do_write(10'h309, 0, 16'hA500, 0);          // odd byte on high lane
    do_read (10'h309, 0, 0);
    do_write(10'h304, 0, 16'h1111, 1);          // R2 DMA cycle
    do_read (10'h304, 0, 1);
    do_write(10'h2F4, 0, 16'h2222, 0);          // R1 outside window
    do_write(10'h30F, 1, 16'h0077, 0);          // top of window

    // R9 bounded stretch
    @(negedge clk_i);
    sa_i = 10'h300; sbhe_ni = 0; reg_ready_i = 0; ior_ni = 0;
    n = 0;
    #1 if (chrdy_oe_o) n++;
    for (int k = 0; k < 15; k++) begin @(negedge clk_i); if (chrdy_oe_o) n++; end
    chk(n == MAXW, "R9 stretch limit", n, MAXW);
    ior_ni = 1; reg_ready_i = 1;

    // R9 release on ready
    @(negedge clk_i);
    reg_ready_i = 0; ior_ni = 0;
    #1 chk(chrdy_oe_o == 1, "R9 stretch active", chrdy_oe_o, 1);
    chk(nows_oe_o == 0, "R10 exclusive", nows_oe_o, 0);
    repeat (2) @(negedge clk_i);
    reg_ready_i = 1;
    #1 chk(chrdy_oe_o == 0, "R9 release", chrdy_oe_o, 0);
    @(negedge clk_i);
    ior_ni = 1;

    // constrained random
    for (int t = 0; t < 80; t++) begin
      logic [9:0] a;
      logic sb, aen;
      a   = ($urandom % 5 == 0) ? 10'($urandom) : {6'h30, 4'($urandom)};
      sb  = 1'($urandom);
      aen = ($urandom % 8 == 0);
      if ($urandom % 2) do_write(a, sb, 16'($urandom), aen);
      else              do_read(a, sb, aen);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule